// File: doc/BRIEF.md
# Comparator Control and Status Interface

This block is the digital side of an analog threshold comparator inside a small power-control peripheral. Software programs it through two byte-wide registers on a simple address/write-enable/read-data bus. The control register holds a 6-bit threshold code and a reference-select bit, and it returns the live comparator result in its lowest bit. The mode register holds the comparator enable, the analog input-pin select and a bit that bypasses the shutdown-request path. The block drives the threshold code, the reference mux select, the input-pin select and the analog enable straight to the analog macro.

The raw comparator decision enters through a two-flop synchronizer. The result is then qualified. It reads as 0 while the comparator is disabled, while the chip is halted, and for a fixed settling window after halt ends. Each rising edge of the qualified result raises a single-cycle request to switch the PWM output off, unless the bypass bit is set. During the settling window the result is masked but the edge detector keeps tracking the unmasked value. A comparator that is already high when the window ends therefore raises no false shutdown request.

Top module: `cmp_ctrl`

## Requirements
- R1: After reset both registers read 0x00, and `cmp_en`, `in_sel`, `ref_sel`, `thr_code` and `pwm_off` are all 0. The comparator is then disabled and the shutdown path is active.
- R2: A write to address 0xA0 stores data bits 7..2 as the threshold code and data bit 1 as the reference select. A reference select of 1 picks the error-amplifier output and 0 picks the programmed threshold. Both appear on their outputs in the cycle after the write. A read of 0xA0 returns {code, select, result}, and data bit 0 of a write is discarded.
- R3: A write to address 0xA1 stores bit 7 as comparator enable, bit 6 as input-pin select and bit 0 as shutdown bypass. `in_sel` is 0 for the first pin and 1 for the second. A read of 0xA1 returns these three bits in the same places, and the other bits read as 0.
- R4: While the comparator is enabled, not halted and settled, the result bit equals the raw input delayed by two clock edges. While it is disabled, the result reads 0.
- R5: While `halt` is high, `cmp_en` is 0 and the result reads 0 in that same cycle, and no shutdown request is raised.
- R6: After `halt` falls, the result reads 0 for 10 cycles and becomes valid at the 10th rising clock edge after the fall. A qualified result that is already high when the window ends raises no shutdown request.
- R7: With bypass at 0, each rising edge of the qualified result raises `pwm_off` for exactly one cycle, in the cycle after the result first reads 1.
- R8: With bypass at 1, `pwm_off` stays 0 whatever the comparator does.
- R9: Rewriting the threshold code or the reference select while the comparator runs leaves the enable and the current result unchanged and raises no request.
- R10: A write to any address other than 0xA0 and 0xA1 changes no register, and a read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| halt | input | 1 | Chip halt state |
| cmp_raw | input | 1 | Raw analog comparator decision, asynchronous |
| cmp_en | output | 1 | Analog comparator enable |
| thr_code | output | 6 | Threshold level code |
| ref_sel | output | 1 | Inverting-input mux select, 1 selects the error amplifier |
| in_sel | output | 1 | Non-inverting input pin select |
| pwm_off | output | 1 | Single-cycle PWM shutdown request |

## Verification
A wrong settle count shows up at the 10-cycle boundary after halt. The result bit then turns valid one or more cycles early or late, and the bench reads it on every cycle of that window. An edge register that tracks the masked result instead of the live one makes a spurious `pwm_off` pulse appear within one cycle of the window closing. A broken synchronizer depth moves the first read-back of the result and the shutdown pulse off their expected cycles, which the scoreboard matches exactly. Register decode faults appear at once on the read-back of the next access.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int REG_W  = 8;
  localparam int CODE_W = 6;

  // mode register field positions
  localparam int MODE_EN_BIT  = 7;
  localparam int MODE_SEL_BIT = 6;
  localparam int MODE_BYP_BIT = 0;

  typedef struct packed {
    logic [CODE_W-1:0] thr;
    logic              loop_sel;
  } ctrl_t;

  typedef struct packed {
    logic en;
    logic sel;
    logic byp;
  } mode_t;
endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] ff_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff_q <= '0;
    end else begin
      ff_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/cmpc_settle.sv
module cmpc_settle #(
  parameter int SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic settled
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = halt || (cnt_q != '0);
    cnt_d  = halt ? LOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign settled = (cnt_q == '0);

  AST_WINDOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> !settled); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R6
endmodule

// File: rtl/cmpc_qual.sv
module cmpc_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_s,
  input  logic en,
  input  logic halt,
  input  logic settled,
  input  logic byp,
  output logic cout,
  output logic pwm_off
);
  logic live, rise;
  logic prev_q, pwm_q;

  always_comb begin
    live = raw_s & en & ~halt;
    cout = live & settled;
    rise = cout & ~prev_q;
  end

  // edge history follows the unmasked value so the window end is silent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      prev_q <= live;
      pwm_q  <= rise & ~byp;
    end
  end

  assign pwm_off = pwm_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_q |=> !pwm_q); // R7
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_q |-> !$past(byp)); // R8
  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_q |-> !$past(halt)); // R5
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import cmpc_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hA0,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 8'hA1,
  parameter int                SETTLE_CYC = 10,
  parameter int                SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              halt,
  input  logic              cmp_raw,
  output logic              cmp_en,
  output logic [CODE_W-1:0] thr_code,
  output logic              ref_sel,
  output logic              in_sel,
  output logic              pwm_off
);
  logic  rst_s_n, raw_s, settled, cout;
  ctrl_t ctrl_q, ctrl_d;
  mode_t mode_q, mode_d;
  logic  ctrl_we, mode_we;

  cmpc_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_s_n));

  cmpc_sync #(.W(1), .STAGES(SYNC_STG)) u_raw_sync (
    .clk(clk), .arst_n(rst_s_n), .d(cmp_raw), .q(raw_s));

  cmpc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_s_n), .halt(halt), .settled(settled));

  cmpc_qual u_qual (
    .clk(clk), .rst_n(rst_s_n), .raw_s(raw_s), .en(mode_q.en),
    .halt(halt), .settled(settled), .byp(mode_q.byp),
    .cout(cout), .pwm_off(pwm_off));

  always_comb begin
    ctrl_we = bus_wr && (bus_addr == CTRL_ADDR);
    mode_we = bus_wr && (bus_addr == MODE_ADDR);
    ctrl_d.thr      = bus_wdata[REG_W-1:2];
    ctrl_d.loop_sel = bus_wdata[1];
    mode_d.en       = bus_wdata[MODE_EN_BIT];
    mode_d.sel      = bus_wdata[MODE_SEL_BIT];
    mode_d.byp      = bus_wdata[MODE_BYP_BIT];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) begin
      bus_rdata = {ctrl_q.thr, ctrl_q.loop_sel, cout};
    end else if (bus_addr == MODE_ADDR) begin
      bus_rdata[MODE_EN_BIT]  = mode_q.en;
      bus_rdata[MODE_SEL_BIT] = mode_q.sel;
      bus_rdata[MODE_BYP_BIT] = mode_q.byp;
    end
  end

  assign cmp_en   = mode_q.en & ~halt;
  assign thr_code = ctrl_q.thr;
  assign ref_sel  = ctrl_q.loop_sel;
  assign in_sel   = mode_q.sel;

  AST_THR_UPDATE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && bus_addr == CTRL_ADDR) |=> (thr_code == $past(bus_wdata[REG_W-1:2]))); // R2
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && bus_addr != CTRL_ADDR && bus_addr != MODE_ADDR)
      |=> ($stable(thr_code) && $stable(in_sel) && $stable(ref_sel))); // R10
endmodule

// File: tb/cmp_ctrl_test.sv
`timescale 1ns/1ps
module cmp_ctrl_test;
  localparam logic [7:0] A_CTRL = 8'hA0;
  localparam logic [7:0] A_MODE = 8'hA1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       halt;
  logic       cmp_raw;
  logic       cmp_en;
  logic [5:0] thr_code;
  logic       ref_sel;
  logic       in_sel;
  logic       pwm_off;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  cmp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt(halt),
    .cmp_raw(cmp_raw), .cmp_en(cmp_en), .thr_code(thr_code),
    .ref_sel(ref_sel), .in_sel(in_sel), .pwm_off(pwm_off));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] e);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, e);
  endtask

  // driver side: raw input change, expected pulse three edges later
  task automatic drive_raw(input logic v, input bit expect_pulse);
    cmp_raw = v;
    if (expect_pulse) exp_q.push_back(cyc + 3);
  endtask

  // monitor: compares every pwm_off pulse with the expected queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL R7 missed pulse actual=none expected=cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (pwm_off) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
        end else begin
          errors++;
          $display("FAIL R7/R8 pulse actual=cycle %0d expected=none", cyc);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    halt = 1'b0; cmp_raw = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    mon_on = 1'b1;

    // R1 reset state
    rd_chk("R1 ctrl reset", A_CTRL, 8'h00);
    rd_chk("R1 mode reset", A_MODE, 8'h00);
    chk("R1 cmp_en", cmp_en, 0);
    chk("R1 in_sel", in_sel, 0);
    chk("R1 ref_sel", ref_sel, 0);
    chk("R1 thr_code", thr_code, 0);
    chk("R1 pwm_off", pwm_off, 0);

    // R3 enable
    wr(A_MODE, 8'h80);
    rd_chk("R3 mode enable", A_MODE, 8'h80);
    chk("R3 cmp_en", cmp_en, 1);
    chk("R3 in_sel first pin", in_sel, 0);

    // R2 control write, bit 0 discarded
    wr(A_CTRL, 8'hAB);
    rd_chk("R2 ctrl readback", A_CTRL, 8'hAA);
    chk("R2 thr_code", thr_code, 6'h2A);
    chk("R2 ref_sel amp", ref_sel, 1);

    // R4 / R7 rising result
    drive_raw(1'b1, 1'b1);
    tick(2);
    rd_chk("R4 result after sync", A_CTRL, 8'hAB);
    tick(2);

    // R9 threshold rewrite on the fly
    wr(A_CTRL, 8'h14);
    chk("R9 thr_code", thr_code, 6'h05);
    chk("R9 ref_sel level", ref_sel, 0);
    chk("R9 cmp_en kept", cmp_en, 1);
    rd_chk("R9 result kept", A_CTRL, 8'h15);
    tick(3);

    // R4 falling, second rising edge
    drive_raw(1'b0, 1'b0);
    tick(3);
    rd_chk("R4 result low", A_CTRL, 8'h14);
    drive_raw(1'b1, 1'b1);
    tick(4);

    // R4 disabled reads 0, re-enable gives an edge
    wr(A_MODE, 8'h00);
    rd_chk("R4 disabled result", A_CTRL, 8'h14);
    tick(2);
    exp_q.push_back(cyc + 2);
    wr(A_MODE, 8'h80);
    rd_chk("R4 re-enabled result", A_CTRL, 8'h15);
    tick(3);

    // R8 bypass
    wr(A_MODE, 8'h81);
    drive_raw(1'b0, 1'b0);
    tick(3);
    drive_raw(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R8 no request", pwm_off, 0);
    end
    rd_chk("R8 result high", A_CTRL, 8'h15);

    // R3 second pin, filter path back on
    wr(A_MODE, 8'hC0);
    chk("R3 in_sel second pin", in_sel, 1);
    tick(2);

    // R5 / R6 halt with input high
    halt = 1'b1;
    #1;
    chk("R5 cmp_en off", cmp_en, 0);
    rd_chk("R5 result off", A_CTRL, 8'h14);
    tick(3);
    halt = 1'b0;
    for (int i = 0; i < 10; i++) begin
      rd_chk("R6 window masked", A_CTRL, 8'h14);
      tick();
    end
    rd_chk("R6 valid after window", A_CTRL, 8'h15);
    chk("R6 cmp_en back", cmp_en, 1);
    tick(3);

    // R6 input rises inside the window
    halt = 1'b1;
    drive_raw(1'b0, 1'b0);
    tick(4);
    halt = 1'b0;
    tick(2);
    drive_raw(1'b1, 1'b0);
    tick(3);
    rd_chk("R6 masked late rise", A_CTRL, 8'h14);
    tick(5);
    rd_chk("R6 valid late rise", A_CTRL, 8'h15);
    tick(3);

    // R10 stray address
    wr(8'hA3, 8'h55);
    rd_chk("R10 ctrl kept", A_CTRL, 8'h15);
    rd_chk("R10 mode kept", A_MODE, 8'hC0);
    rd_chk("R10 stray read", 8'hA3, 8'h00);

    // R3 unused bits read 0
    wr(A_MODE, 8'hFF);
    rd_chk("R3 mode unused bits", A_MODE, 8'hC1);
    tick(4);

    chk("R7 all pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule